// File: doc/BRIEF.md
# Maskable Alarm Comparator with Shared Open-Drain Output

This block watches the current calendar time and raises a sticky alarm flag when the time agrees with five programmable alarm fields: seconds, minutes, hours, date and month. Every field has its own ignore bit, so one setting can make the alarm fire on every second, once a minute, once an hour, once a day or once a month. The timekeeping counters sit outside. They supply the time as BCD values and give a one-cycle strobe each time the seconds advance. The comparison runs only on that strobe, so each matching second yields exactly one alarm event.

The same block drives one open-drain pin that serves four purposes. Three control inputs choose the function. A calibration request puts a 512 Hz reference on the pin. Otherwise the pin carries a square wave whose frequency is set by a 2-bit selector, or it carries the active-low alarm, or it is released. All square waves come from taps of one divider chain, which advances on a base strobe that runs at twice the highest output frequency. The alarm flag clears when the status register that holds it is read. A status-read strobe reports that read to the block.

Top module: `rtc_alarm_pin_unit`

## Requirements
- R1: An alarm field is written when `fld_we` is high, with `fld_sel` choosing the field: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month. A `fld_sel` value of 5 to 7 changes nothing. In each field, bit 7 is the ignore bit: 1 leaves the field out of the comparison and 0 includes it. The low 7, 7, 6, 6 and 5 bits (in field order) are compared with the matching time input. Reset loads every field with 8'h80.
- R2: When every field has its ignore bit set, each `sec_tick` with `alm_en` high sets the alarm flag.
- R3: The flag is set only on a clock edge where `sec_tick` is high, `alm_en` is high and every included field equals its time input. A mismatch in any included field prevents the set.
- R4: Once set, the flag holds until a clock edge with `status_rd` high clears it. If `status_rd` and a qualifying alarm event fall on the same edge, the flag ends up set.
- R5: With `alm_en` low, no new alarm event occurs, but a flag that is already set stays set and the pin stays pulled low.
- R6: With `cal_mode` high, the pin carries the 512 Hz reference, with a half period of 64 base strobes, whatever the other controls are. Alarm events still set the flag.
- R7: With `cal_mode` low and `alm_sel` low, the pin carries a square wave chosen by `freq_sel`: 0 gives 1 Hz, 1 gives 512 Hz, 2 gives 4096 Hz and 3 gives 32768 Hz. The half periods are 32768, 64, 8 and 1 base strobes. Alarm events set only the flag.
- R8: With `cal_mode` low and `alm_sel` high, `acs_pull_low` equals the alarm flag, delayed by one clock.
- R9: With `cal_mode` low, `alm_sel` high and the flag clear, the pin is released (`acs_pull_low` = 0), including when `alm_en` is low.
- R10: The divider advances only on `base_en`. After reset the flag is 0 and the pin is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_en | input | 1 | Divider base strobe, at twice the highest square-wave frequency |
| sec_tick | input | 1 | One-cycle strobe when the seconds count advances |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 6 | Current hours, BCD, 24-hour |
| now_date | input | 6 | Current day of month, BCD |
| now_month | input | 5 | Current month, BCD |
| fld_we | input | 1 | Alarm field write strobe |
| fld_sel | input | 3 | Alarm field select |
| fld_wdata | input | 8 | Alarm field write data, bit 7 is the ignore bit |
| cal_mode | input | 1 | Calibration reference request |
| alm_sel | input | 1 | 1 routes the alarm to the pin, 0 routes the square wave |
| alm_en | input | 1 | Alarm event enable |
| freq_sel | input | 2 | Square-wave frequency select |
| status_rd | input | 1 | Status register read strobe, clears the flag |
| alarm_flag | output | 1 | Sticky alarm flag |
| acs_pull_low | output | 1 | 1 pulls the open-drain pin low, 0 releases it |

## Verification
The bench measures the half period of the pin for each frequency code and for the calibration reference. It waits until the pin has toggled twice before timing, so a wrong tap or a swapped selector code gives a half period far from the expected one. Some tests combine a read strobe and an alarm event on the same edge, and others clear the enable while the flag is set. A design that gives the read priority loses that alarm, and one that ties the pin to the enable releases an alarm that is still pending. The bench also runs the comparator with one included field mismatched, with a write to an unused field select, and with the month ignore bit set. A design with a wrong field mask or a loose select decode then fires when it should not, or stays silent when it should fire.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int NUM_FIELDS = 5;
  localparam int FIELD_W    = 8;
  localparam int SEL_W      = 3;

  typedef enum logic [SEL_W-1:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_DATE  = 3'd3,
    FLD_MONTH = 3'd4
  } fld_e;

  typedef enum logic [1:0] {
    FQ_1HZ   = 2'd0,
    FQ_512HZ = 2'd1,
    FQ_4KHZ  = 2'd2,
    FQ_32KHZ = 2'd3
  } freq_e;

  // number of value bits compared for each field, seconds first
  function automatic int fld_value_bits(input int idx);
    case (idx)
      0, 1:    return 7;
      2, 3:    return 6;
      default: return 5;
    endcase
  endfunction
endpackage

// File: rtl/alm_field_bank.sv
module alm_field_bank
  import alm_pkg::*;
#(
  parameter int NUM = NUM_FIELDS,
  parameter int W   = FIELD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] sel,
  input  logic [W-1:0]     wdata,
  input  logic [NUM*W-1:0] now_flat,
  output logic             hit_all
);
  localparam logic [W-1:0] RST_VAL = W'(1) << (W - 1);

  logic [NUM-1:0] hit;

  for (genvar i = 0; i < NUM; i++) begin : g_fld
    localparam int           VB    = fld_value_bits(i);
    localparam logic [W-1:0] VMASK = W'((1 << VB) - 1);

    logic [W-1:0] val_q;
    logic [W-1:0] val_d;
    logic [W-1:0] now_v;

    assign now_v = now_flat[i*W +: W];

    always_comb begin
      val_d = val_q;
      if (we && (sel == SEL_W'(i))) begin
        val_d = wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= RST_VAL;
      end else begin
        val_q <= val_d;
      end
    end

    // ignore bit set, or value bits agree
    assign hit[i] = val_q[W-1] | (((val_q ^ now_v) & VMASK) == '0);
  end

  assign hit_all = &hit;
endmodule

// File: rtl/alm_flag_ctl.sv
module alm_flag_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_tick,
  input  logic alm_en,
  input  logic hit_all,
  input  logic status_rd,
  output logic flag
);
  logic flag_q;
  logic flag_d;
  logic event_now;

  assign event_now = sec_tick & alm_en & hit_all;

  always_comb begin
    flag_d = flag_q;
    if (status_rd) begin
      flag_d = 1'b0;
    end
    if (event_now) begin
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/alm_wave_div.sv
module alm_wave_div
  import alm_pkg::*;
#(
  parameter int DIV_BITS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       base_en,
  input  logic [1:0] freq_sel,
  output logic       wave_sel,
  output logic       wave_cal
);
  // bit k of the counter toggles every 2^k base strobes
  localparam int TAP_1HZ   = DIV_BITS - 1;
  localparam int TAP_512HZ = DIV_BITS - 10;
  localparam int TAP_4KHZ  = DIV_BITS - 13;
  localparam int TAP_32KHZ = DIV_BITS - 16;

  logic [DIV_BITS-1:0] div_q;
  logic [DIV_BITS-1:0] div_d;

  always_comb begin
    div_d = div_q;
    if (base_en) begin
      div_d = div_q + DIV_BITS'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else begin
      div_q <= div_d;
    end
  end

  always_comb begin
    case (freq_e'(freq_sel))
      FQ_1HZ:   wave_sel = div_q[TAP_1HZ];
      FQ_512HZ: wave_sel = div_q[TAP_512HZ];
      FQ_4KHZ:  wave_sel = div_q[TAP_4KHZ];
      default:  wave_sel = div_q[TAP_32KHZ];
    endcase
  end

  assign wave_cal = div_q[TAP_512HZ];
endmodule

// File: rtl/alm_pin_mux.sv
module alm_pin_mux (
  input  logic clk,
  input  logic rst_n,
  input  logic cal_mode,
  input  logic alm_sel,
  input  logic wave_sel,
  input  logic wave_cal,
  input  logic flag,
  output logic pull_low
);
  logic pull_q;
  logic pull_d;

  // priority: calibration, then square wave, then alarm
  always_comb begin
    if (cal_mode) begin
      pull_d = ~wave_cal;
    end else if (!alm_sel) begin
      pull_d = ~wave_sel;
    end else begin
      pull_d = flag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pull_q <= 1'b0;
    end else begin
      pull_q <= pull_d;
    end
  end

  assign pull_low = pull_q;
endmodule

// File: rtl/rtc_alarm_pin_unit.sv
module rtc_alarm_pin_unit
  import alm_pkg::*;
#(
  parameter int DIV_BITS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       base_en,
  input  logic       sec_tick,
  input  logic [6:0] now_sec,
  input  logic [6:0] now_min,
  input  logic [5:0] now_hour,
  input  logic [5:0] now_date,
  input  logic [4:0] now_month,
  input  logic       fld_we,
  input  logic [2:0] fld_sel,
  input  logic [7:0] fld_wdata,
  input  logic       cal_mode,
  input  logic       alm_sel,
  input  logic       alm_en,
  input  logic [1:0] freq_sel,
  input  logic       status_rd,
  output logic       alarm_flag,
  output logic       acs_pull_low
);
  logic [NUM_FIELDS*FIELD_W-1:0] now_flat;
  logic hit_all;
  logic flag;
  logic wave_sel;
  logic wave_cal;

  assign now_flat = {FIELD_W'(now_month), FIELD_W'(now_date), FIELD_W'(now_hour),
                     FIELD_W'(now_min), FIELD_W'(now_sec)};

  alm_field_bank #(.NUM(NUM_FIELDS), .W(FIELD_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (fld_we),
    .sel      (fld_sel),
    .wdata    (fld_wdata),
    .now_flat (now_flat),
    .hit_all  (hit_all)
  );

  alm_flag_ctl u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_tick  (sec_tick),
    .alm_en    (alm_en),
    .hit_all   (hit_all),
    .status_rd (status_rd),
    .flag      (flag)
  );

  alm_wave_div #(.DIV_BITS(DIV_BITS)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .base_en  (base_en),
    .freq_sel (freq_sel),
    .wave_sel (wave_sel),
    .wave_cal (wave_cal)
  );

  alm_pin_mux u_mux (
    .clk      (clk),
    .rst_n    (rst_n),
    .cal_mode (cal_mode),
    .alm_sel  (alm_sel),
    .wave_sel (wave_sel),
    .wave_cal (wave_cal),
    .flag     (flag),
    .pull_low (acs_pull_low)
  );

  assign alarm_flag = flag;
endmodule

// File: rtl/alm_chk.sv
module alm_chk (
  input logic clk,
  input logic rst_n,
  input logic sec_tick,
  input logic status_rd,
  input logic alm_en,
  input logic cal_mode,
  input logic alm_sel,
  input logic base_en,
  input logic alarm_flag,
  input logic acs_pull_low
);
  a_r4_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_flag && !status_rd |=> alarm_flag);

  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_flag && status_rd && !sec_tick |=> !alarm_flag);

  a_r3_no_set_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_flag && !sec_tick |=> !alarm_flag);

  a_r5_no_event_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_flag && !alm_en |=> !alarm_flag);

  a_r8_pin_tracks_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_mode && alm_sel |=> acs_pull_low == $past(alarm_flag));

  a_r10_divider_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_mode && !base_en) ##1 (cal_mode && !base_en) |=> $stable(acs_pull_low));
endmodule

bind rtc_alarm_pin_unit alm_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sec_tick     (sec_tick),
  .status_rd    (status_rd),
  .alm_en       (alm_en),
  .cal_mode     (cal_mode),
  .alm_sel      (alm_sel),
  .base_en      (base_en),
  .alarm_flag   (alarm_flag),
  .acs_pull_low (acs_pull_low)
);

// File: tb/sim_rtc_alarm_pin_unit.sv
module sim_rtc_alarm_pin_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       base_en;
  logic       sec_tick;
  logic [6:0] now_sec;
  logic [6:0] now_min;
  logic [5:0] now_hour;
  logic [5:0] now_date;
  logic [4:0] now_month;
  logic       fld_we;
  logic [2:0] fld_sel;
  logic [7:0] fld_wdata;
  logic       cal_mode;
  logic       alm_sel;
  logic       alm_en;
  logic [1:0] freq_sel;
  logic       status_rd;
  logic       alarm_flag;
  logic       acs_pull_low;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  rtc_alarm_pin_unit u0 (
    .clk(clk), .rst_n(rst_n), .base_en(base_en), .sec_tick(sec_tick),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
    .now_date(now_date), .now_month(now_month), .fld_we(fld_we),
    .fld_sel(fld_sel), .fld_wdata(fld_wdata), .cal_mode(cal_mode),
    .alm_sel(alm_sel), .alm_en(alm_en), .freq_sel(freq_sel),
    .status_rd(status_rd), .alarm_flag(alarm_flag), .acs_pull_low(acs_pull_low)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr_fld(input logic [2:0] sel, input logic [7:0] data);
    @(negedge clk);
    fld_we = 1'b1; fld_sel = sel; fld_wdata = data;
    @(negedge clk);
    fld_we = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic rd_status();
    @(negedge clk); status_rd = 1'b1;
    @(negedge clk); status_rd = 1'b0;
  endtask

  task automatic all_ignore();
    for (int i = 0; i < 5; i++) wr_fld(3'(i), 8'h80);
  endtask

  task automatic set_now(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                         input logic [7:0] d, input logic [7:0] mo);
    @(negedge clk);
    now_sec = s[6:0]; now_min = m[6:0]; now_hour = h[5:0];
    now_date = d[5:0]; now_month = mo[4:0];
  endtask

  // skip two pin edges, then count cycles to the next edge
  task automatic measure_half(input string tag, input int exp);
    logic last;
    int   n;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      last = acs_pull_low; n = 0;
      while (acs_pull_low == last && n < 70000) begin
        @(negedge clk); n++;
      end
    end
    last = acs_pull_low; n = 0;
    while (acs_pull_low == last && n < 70000) begin
      @(negedge clk); n++;
    end
    check(tag, n, exp);
  endtask

  task automatic t_reset();
    check("R10 reset flag", alarm_flag, 0);
    check("R10 reset pin released", acs_pull_low, 0);
  endtask

  task automatic t_every_second();
    tick();
    check("R2 flag on tick with all ignored", alarm_flag, 1);
    @(negedge clk);
    check("R8 pin low one clock after flag", acs_pull_low, 1);
    repeat (5) @(negedge clk);
    check("R4 flag sticky", alarm_flag, 1);
    rd_status();
    check("R4 read clears flag", alarm_flag, 0);
    @(negedge clk);
    check("R8 pin released after clear", acs_pull_low, 0);
    tick();
    check("R2 fires again next tick", alarm_flag, 1);
    rd_status();
  endtask

  task automatic t_no_tick();
    repeat (20) @(negedge clk);
    check("R3 no flag without tick", alarm_flag, 0);
  endtask

  task automatic t_seconds_match();
    all_ignore();
    wr_fld(3'd0, 8'h25);
    set_now(8'h24, 8'h07, 8'h01, 8'h01, 8'h01);
    tick();
    check("R3 seconds mismatch no flag", alarm_flag, 0);
    set_now(8'h25, 8'h33, 8'h01, 8'h01, 8'h01);
    tick();
    check("R3 seconds match sets flag", alarm_flag, 1);
    rd_status();
  endtask

  task automatic t_full_match();
    wr_fld(3'd0, 8'h58);
    wr_fld(3'd1, 8'h59);
    wr_fld(3'd2, 8'h23);
    wr_fld(3'd3, 8'h31);
    wr_fld(3'd4, 8'h12);
    set_now(8'h58, 8'h59, 8'h23, 8'h31, 8'h12);
    tick();
    check("R3 all five fields match", alarm_flag, 1);
    rd_status();
    set_now(8'h58, 8'h59, 8'h23, 8'h31, 8'h11);
    tick();
    check("R3 month mismatch no flag", alarm_flag, 0);
    wr_fld(3'd5, 8'h80);
    tick();
    check("R1 unused select has no effect", alarm_flag, 0);
    wr_fld(3'd4, 8'h92);
    tick();
    check("R1 month ignore bit", alarm_flag, 1);
    rd_status();
    all_ignore();
  endtask

  task automatic t_set_wins();
    @(negedge clk); sec_tick = 1'b1; status_rd = 1'b1;
    @(negedge clk); sec_tick = 1'b0; status_rd = 1'b0;
    check("R4 set wins over read", alarm_flag, 1);
    rd_status();
  endtask

  task automatic t_enable_off();
    tick();
    @(negedge clk); alm_en = 1'b0;
    tick();
    check("R5 flag kept with enable low", alarm_flag, 1);
    check("R5 pin kept low with enable low", acs_pull_low, 1);
    rd_status();
    check("R5 read still clears", alarm_flag, 0);
    @(negedge clk);
    check("R9 pin released, enable low, flag clear", acs_pull_low, 0);
    tick();
    check("R5 no new event with enable low", alarm_flag, 0);
    @(negedge clk);
    check("R9 pin stays released", acs_pull_low, 0);
    alm_en = 1'b1;
  endtask

  task automatic t_cal();
    @(negedge clk); cal_mode = 1'b1; freq_sel = 2'd3;
    measure_half("R6 calibration half period", 64);
    tick();
    check("R6 alarm sets flag in calibration", alarm_flag, 1);
    measure_half("R6 calibration ignores flag", 64);
    @(negedge clk); cal_mode = 1'b0;
    @(negedge clk);
    check("R8 pending alarm shown after calibration", acs_pull_low, 1);
    rd_status();
  endtask

  task automatic t_square();
    @(negedge clk); alm_sel = 1'b0; freq_sel = 2'd3;
    measure_half("R7 32768 Hz half period", 1);
    @(negedge clk); freq_sel = 2'd2;
    measure_half("R7 4096 Hz half period", 8);
    @(negedge clk); freq_sel = 2'd1;
    measure_half("R7 512 Hz half period", 64);
    tick();
    check("R7 alarm sets flag in wave mode", alarm_flag, 1);
    measure_half("R7 wave ignores flag", 64);
    rd_status();
  endtask

  task automatic t_base_gate();
    logic first;
    int   changes;
    @(negedge clk); freq_sel = 2'd3; base_en = 1'b0;
    repeat (3) @(negedge clk);
    first = acs_pull_low; changes = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (acs_pull_low != first) changes++;
    end
    check("R10 divider frozen without base strobe", changes, 0);
    base_en = 1'b1;
  endtask

  task automatic t_one_hz();
    @(negedge clk); freq_sel = 2'd0;
    measure_half("R7 1 Hz half period", 32768);
    @(negedge clk); alm_sel = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; base_en = 1'b1; sec_tick = 1'b0;
    now_sec = '0; now_min = '0; now_hour = '0; now_date = 6'h01; now_month = 5'h01;
    fld_we = 1'b0; fld_sel = '0; fld_wdata = '0;
    cal_mode = 1'b0; alm_sel = 1'b1; alm_en = 1'b1; freq_sel = 2'd0; status_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_every_second();
    t_no_tick();
    t_seconds_match();
    t_full_match();
    t_set_wins();
    t_enable_off();
    t_cal();
    t_square();
    t_base_gate();
    t_one_hz();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule